// File: doc/BRIEF.md
# Touch Sample Filter and Validator

This block turns a burst of packed touch-panel samples into one filtered touch report. A rising edge on the FIFO-level interrupt starts an event. The block checks the FIFO status word once. If an overrun is flagged, it drains the FIFO and reports nothing. If not, it pops a window of up to four sample words. Each axis field is inverted against full scale. The two middle samples are averaged to give the position. The outer two samples only serve as guards.

The report marks a touch only when the whole window of four samples arrived and the final sample still shows the pen down. Any shorter window, or a final sample with the pen lifted, gives a touch-up report, and the X and Y outputs keep their last touch value. The FIFO storage and the measurement sequencer are outside this block. It only drives the pop strobe and reads the status and head word.

Top module: `touch_report_filter`

## Requirements
- R1: Each rising edge of `fifo_irq` starts one event. An edge that arrives while an event is in progress is remembered and served after the current one ends, so no edge is lost.
- R2: When status bit 8 (overrun) is 1 at the start of an event, the block pops words until status bit 7 (empty) is 1 and issues no report for that event.
- R3: During collection the block pops at most four words per event. It stops early when the empty bit is 1, and it never pops while the empty bit is 1.
- R4: Each sample's X is 0x3FF minus data bits 25:16, and its Y is 0x3FF minus data bits 9:0.
- R5: The reported X and Y are the floor of the average of the inverted values of the second and third samples. The sum is formed in 11 bits, so the 0x3FF+0x3FF case gives 0x3FF. Both outputs stay in the range 0 to 0x3FF.
- R6: `rpt_touch` is 1 only when exactly four samples were read and bit 31 (pen lifted) of the fourth sample is 0. The pen bits of the first three samples have no effect.
- R7: A report with `rpt_touch` 0 leaves `rpt_x` and `rpt_y` at their previous values.
- R8: `rpt_valid` is high for exactly one clock per event that is not an overrun event.
- R9: While `rst_n` is low and after it is released, `rpt_valid`, `rpt_touch`, `rpt_x`, `rpt_y` and `fifo_pop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| fifo_irq | input | 1 | FIFO-level interrupt; its rising edge starts an event |
| fifo_status | input | 16 | FIFO status; bit 8 overrun, bit 7 empty |
| fifo_data | input | 32 | FIFO head word: bit 31 pen lifted, 25:16 raw X, 9:0 raw Y |
| fifo_pop | output | 1 | Removes the head word at the next clock edge |
| rpt_valid | output | 1 | One-clock report strobe |
| rpt_x | output | 10 | Filtered X position |
| rpt_y | output | 10 | Filtered Y position |
| rpt_touch | output | 1 | 1 = touch-down report, 0 = touch-up report |

## Verification
A sample counter stuck at the wrong value shows at once in the FIFO fill left behind after one event. Too many pops drain words that belong to the next event. Too few leave extra words and turn a valid touch into a touch-up. A slot that captures the wrong sample moves the reported position away from the computed average in the first report. A lost pending flag shows as a missing second strobe a few tens of clocks later. A wrong hold path moves the position on a touch-up report, and this is visible in the same cycle as the strobe.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  parameter int DATA_W    = 32;
  parameter int STAT_W    = 16;
  parameter int AXIS_W    = 10;
  parameter int X_LSB     = 16;
  parameter int Y_LSB     = 0;
  parameter int PEN_BIT   = 31;
  parameter int OVR_BIT   = 8;
  parameter int EMPTY_BIT = 7;
  parameter int WIN       = 4;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_CHECK   = 2'd1,
    S_FLUSH   = 2'd2,
    S_COLLECT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tsf_event_latch.sv
module tsf_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic accept,
  output logic pending
);
  logic irq_q, irq_q_n, pend_n;

  always_comb begin
    irq_q_n = irq;
    pend_n  = (pending & ~accept) | (irq & ~irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      irq_q   <= irq_q_n;
      pending <= pend_n;
    end
  end

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !accept) |=> pending); // R1
endmodule

// File: rtl/tsf_seq.sv
module tsf_seq
  import tsf_pkg::*;
#(
  parameter int N_WIN = WIN
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          overrun,
  input  logic                          empty,
  output logic                          accept,
  output logic                          pop,
  output logic [$clog2(N_WIN)-1:0]      pop_idx,
  output logic                          done,
  output logic                          full
);
  localparam int CNT_W = $clog2(N_WIN + 1);
  localparam int IDX_W = $clog2(N_WIN);

  seq_state_e       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    accept  = 1'b0;
    pop     = 1'b0;
    done    = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          cnt_n   = '0;
          state_n = S_CHECK;
        end
      end
      S_CHECK: state_n = overrun ? S_FLUSH : S_COLLECT;
      S_FLUSH: begin
        if (empty) state_n = S_IDLE;
        else       pop     = 1'b1;
      end
      S_COLLECT: begin
        if ((cnt < CNT_W'(N_WIN)) && !empty) begin
          pop   = 1'b1;
          cnt_n = cnt + 1'b1;
        end else begin
          done    = 1'b1;
          state_n = S_IDLE;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  assign pop_idx = cnt[IDX_W-1:0];
  assign full    = (cnt == CNT_W'(N_WIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R3
  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COLLECT && pop) |-> (cnt < CNT_W'(N_WIN))); // R3
  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FLUSH) |-> !done); // R2
endmodule

// File: rtl/tsf_sample_path.sv
module tsf_sample_path
  import tsf_pkg::*;
#(
  parameter int N_WIN = WIN
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pop,
  input  logic [$clog2(N_WIN)-1:0]  pop_idx,
  input  logic [DATA_W-1:0]         data,
  input  logic                      done,
  input  logic                      full,
  output logic                      rpt_valid,
  output logic [AXIS_W-1:0]         rpt_x,
  output logic [AXIS_W-1:0]         rpt_y,
  output logic                      rpt_touch
);
  localparam int IDX_W = $clog2(N_WIN);
  localparam logic [IDX_W-1:0] IDX_A    = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_B    = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_WIN - 1);
  localparam logic [AXIS_W-1:0] FULL_SCALE = '1;

  logic [AXIS_W-1:0] inv_x, inv_y;
  logic [AXIS_W-1:0] ax, ay, bx, by;
  logic [AXIS_W-1:0] ax_n, ay_n, bx_n, by_n;
  logic              pen_up, pen_up_n;
  logic [AXIS_W:0]   sum_x, sum_y;
  logic              touch_ok;
  logic              valid_n, touch_n;
  logic [AXIS_W-1:0] x_n, y_n;

  always_comb begin
    inv_x = FULL_SCALE - data[X_LSB +: AXIS_W];
    inv_y = FULL_SCALE - data[Y_LSB +: AXIS_W];
    ax_n = ax; ay_n = ay; bx_n = bx; by_n = by; pen_up_n = pen_up;
    if (pop && pop_idx == IDX_A)    begin ax_n = inv_x; ay_n = inv_y; end
    if (pop && pop_idx == IDX_B)    begin bx_n = inv_x; by_n = inv_y; end
    if (pop && pop_idx == IDX_LAST) pen_up_n = data[PEN_BIT];
    sum_x    = {1'b0, ax} + {1'b0, bx};
    sum_y    = {1'b0, ay} + {1'b0, by};
    touch_ok = full & ~pen_up;
    valid_n  = done;
    touch_n  = done ? touch_ok : rpt_touch;
    x_n      = (done && touch_ok) ? sum_x[AXIS_W:1] : rpt_x;
    y_n      = (done && touch_ok) ? sum_y[AXIS_W:1] : rpt_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ax <= '0; ay <= '0; bx <= '0; by <= '0;
      pen_up    <= 1'b0;
      rpt_valid <= 1'b0;
      rpt_touch <= 1'b0;
      rpt_x     <= '0;
      rpt_y     <= '0;
    end else begin
      ax <= ax_n; ay <= ay_n; bx <= bx_n; by <= by_n;
      pen_up    <= pen_up_n;
      rpt_valid <= valid_n;
      rpt_touch <= touch_n;
      rpt_x     <= x_n;
      rpt_y     <= y_n;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |=> !rpt_valid); // R8
  AST_UP_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_touch) |-> ($stable(rpt_x) && $stable(rpt_y))); // R7
  AST_TOUCH_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_touch) |-> $past(full)); // R6
endmodule

// File: rtl/touch_report_filter.sv
module touch_report_filter
  import tsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_irq,
  input  logic [STAT_W-1:0] fifo_status,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              rpt_valid,
  output logic [AXIS_W-1:0] rpt_x,
  output logic [AXIS_W-1:0] rpt_y,
  output logic              rpt_touch
);
  localparam int IDX_W = $clog2(WIN);

  logic             pending, accept, done, full;
  logic [IDX_W-1:0] pop_idx;

  tsf_event_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (fifo_irq),
    .accept  (accept),
    .pending (pending)
  );

  tsf_seq #(.N_WIN(WIN)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (pending),
    .overrun (fifo_status[OVR_BIT]),
    .empty   (fifo_status[EMPTY_BIT]),
    .accept  (accept),
    .pop     (fifo_pop),
    .pop_idx (pop_idx),
    .done    (done),
    .full    (full)
  );

  tsf_sample_path #(.N_WIN(WIN)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (fifo_pop),
    .pop_idx   (pop_idx),
    .data      (fifo_data),
    .done      (done),
    .full      (full),
    .rpt_valid (rpt_valid),
    .rpt_x     (rpt_x),
    .rpt_y     (rpt_y),
    .rpt_touch (rpt_touch)
  );
endmodule

// File: tb/touch_report_filter_tb.sv
module touch_report_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_irq = 1'b0;
  logic [15:0] fifo_status;
  logic [31:0] fifo_data;
  logic        fifo_pop, rpt_valid, rpt_touch;
  logic [9:0]  rpt_x, rpt_y;

  always #4 clk = ~clk;

  logic [31:0] mem [16];
  int  wr_ptr = 0;
  int  rd_ptr = 0;
  logic ovr = 1'b0;
  logic empty;
  assign empty       = (rd_ptr == wr_ptr);
  assign fifo_status = {7'b0, ovr, empty, 7'b0};
  assign fifo_data   = mem[rd_ptr[3:0]];

  always @(posedge clk) if (fifo_pop) rd_ptr <= rd_ptr + 1;

  int vcount = 0;
  int dbl = 0;
  logic prev_v = 1'b0;
  int cyc = 0;
  always @(posedge clk) begin
    if (rpt_valid) vcount <= vcount + 1;
    if (rpt_valid && prev_v) dbl <= dbl + 1;
    prev_v <= rpt_valid;
  end

  touch_report_filter u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_irq(fifo_irq), .fifo_status(fifo_status),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .rpt_valid(rpt_valid),
    .rpt_x(rpt_x), .rpt_y(rpt_y), .rpt_touch(rpt_touch)
  );

  int n_tests = 0;
  int n_fail  = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL watchdog: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
      $finish;
    end
  end

  localparam int NV = 6;
  localparam logic [31:0] VW [NV][4] = '{
    '{32'h000003FF, 32'h01000200, 32'h01020201, 32'h03FF0000},
    '{32'h00550055, 32'h000003FF, 32'h000003FF, 32'h00000000},
    '{32'h00000000, 32'h03FF0001, 32'h03FE0000, 32'h00100010},
    '{32'h000003FF, 32'h01000200, 32'h01020201, 32'h83FF0000},
    '{32'h00550055, 32'h000003FF, 32'h000003FF, 32'h00000000},
    '{32'h80000000, 32'h80640032, 32'h80660030, 32'h00000000}
  };
  localparam int VN [NV] = '{4, 4, 4, 4, 3, 4};
  localparam logic [20:0] VEXP [NV] = '{
    {1'b1, 10'h2FE, 10'h1FE},
    {1'b1, 10'h3FF, 10'h000},
    {1'b1, 10'h000, 10'h3FE},
    {1'b0, 10'h000, 10'h3FE},
    {1'b0, 10'h000, 10'h3FE},
    {1'b1, 10'h39A, 10'h3CE}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] w);
    mem[wr_ptr[3:0]] = w;
    wr_ptr = wr_ptr + 1;
  endtask

  task automatic fire();
    @(negedge clk); fifo_irq = 1'b1;
    @(negedge clk); @(negedge clk); fifo_irq = 1'b0;
  endtask

  task automatic wait_report(output bit got);
    int base;
    base = vcount;
    got = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (vcount != base) begin got = 1'b1; break; end
    end
  endtask

  initial begin
    bit got;
    int base;
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", 32'(rpt_valid), 0);
    chk("R9 pop in reset", 32'(fifo_pop), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 outputs after reset", {11'b0, rpt_touch, rpt_x, rpt_y}, 0);

    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < VN[v]; k++) push(VW[v][k]);
      base = vcount;
      fire();
      wait_report(got);
      repeat (4) @(negedge clk);
      chk("R8 one report per event", 32'(vcount - base), 1);
      chk("R6 touch flag", 32'(rpt_touch), 32'(VEXP[v][20]));
      chk("R4 R5 R7 x position", 32'(rpt_x), 32'(VEXP[v][19:10]));
      chk("R4 R5 R7 y position", 32'(rpt_y), 32'(VEXP[v][9:0]));
      chk("R3 fifo drained", 32'(wr_ptr - rd_ptr), 0);
    end

    // R2: overrun event drains the FIFO and stays silent
    for (int k = 0; k < 6; k++) push(32'h01000100);
    ovr = 1'b1;
    base = vcount;
    fire();
    repeat (30) @(negedge clk);
    chk("R2 no report on overrun", 32'(vcount - base), 0);
    chk("R2 fifo flushed", 32'(wr_ptr - rd_ptr), 0);
    chk("R2 position untouched", {12'b0, rpt_x, rpt_y}, {12'b0, 10'h39A, 10'h3CE});
    ovr = 1'b0;

    // R3: six words queued, only four taken
    for (int k = 0; k < 4; k++) push(VW[0][k]);
    push(32'h00000000); push(32'h00000000);
    fire();
    wait_report(got);
    repeat (4) @(negedge clk);
    chk("R3 two words left", 32'(wr_ptr - rd_ptr), 2);
    chk("R5 position from window", {12'b0, rpt_x, rpt_y}, {12'b0, 10'h2FE, 10'h1FE});
    fire();
    wait_report(got);
    repeat (4) @(negedge clk);
    chk("R6 short window is touch-up", 32'(rpt_touch), 0);
    chk("R7 touch-up holds position", {12'b0, rpt_x, rpt_y}, {12'b0, 10'h2FE, 10'h1FE});

    // R1: second edge while busy is served afterwards
    for (int k = 0; k < 4; k++) push(VW[5][k]);
    base = vcount;
    fire();
    fire();
    repeat (80) @(negedge clk);
    chk("R1 pending edge served", 32'(vcount - base), 2);
    chk("R1 empty event is touch-up", 32'(rpt_touch), 0);
    chk("R3 no pop when empty", 32'(wr_ptr - rd_ptr), 0);
    chk("R7 hold after empty event", {12'b0, rpt_x, rpt_y}, {12'b0, 10'h39A, 10'h3CE});
    chk("R8 strobe never two cycles", 32'(dbl), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule